// File: doc/BRIEF.md
# Equalization Adaptation Step Sequencer

This block orders the steps of a link-training adaptation run independently for each lane of a multi-lane link. A receiver continuous-time equalizer (CTLE) adaptation step can be placed ahead of the transmitter-equalization phase, behind it, on both sides, or left out. The CTLE and TX-equalization engines themselves sit outside the block. Each one is driven by a one-cycle start pulse and answers with a done pulse.

Software reaches the block through a small write port and a combinational read port. The configuration word holds the CTLE placement mode and two override enables. The override enables steer where coefficient commands come from: the training logic or software-written registers. One for each direction. The restart word holds one self-clearing bit per lane. Setting a lane's bit throws that lane back to the start of its sequence. When a lane has finished its sequence it raises its training-complete flag.

Top module: `eq_step_seq`

## Requirements
- R1: After reset the configuration word reads 0x0000000C: mode 2'b11 in bits [3:2], partner override enable (bit 0) = 0, local override enable (bit 1) = 0. Every lane begins a run by itself on the first clock after reset.
- R2: With mode 00 a run issues only one `txeq_start` pulse and no `ctle_start` pulse. `train_done` rises on the clock after `txeq_done` is sampled.
- R3: With mode 01 a run issues one `ctle_start` pulse, then waits for `ctle_done`, then issues `txeq_start`, then waits for `txeq_done`, then finishes.
- R4: With mode 10 a run issues `txeq_start` first. After `txeq_done` it issues one `ctle_start` pulse, and it finishes after `ctle_done`.
- R5: With mode 11 a run issues `ctle_start`, then `txeq_start`, then `ctle_start` again. Each step waits for its own done input.
- R6: Every start output is high for exactly one cycle. A lane waits without a time limit until the matching done input is high. A disabled step costs no cycle: the first start pulse appears on the clock after the lane leaves idle, and each following start pulse or `train_done` appears on the clock after the done input is sampled.
- R7: A write to address 1 that has bit i = 1 puts lane i back in idle on that clock edge and clears its `train_done`. The lane's new run starts on the next clock with `ctle_start` or `txeq_start` high. Address 1 always reads 0.
- R8: A write to address 1 whose bit for a lane is 0 leaves that lane's outputs unchanged.
- R9: Each lane captures the mode when its run begins. A mode write in the middle of a run changes neither the order nor the number of steps in that run.
- R10: `partner_cmd_sw` equals bit 0 of the configuration word. 1 selects software-written update commands toward the partner transmitter, and 0 selects the training logic.
- R11: `local_coef_sw` equals bit 1 of the configuration word. 1 selects software-written local transmitter coefficients, and 0 selects the partner's received update commands.
- R12: Configuration bits [31:4] read 0 and ignore writes. Addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address (0 config, 1 restart) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational |
| ctle_done | input | LANES | Per-lane CTLE step done |
| txeq_done | input | LANES | Per-lane TX-equalization done |
| ctle_start | output | LANES | Per-lane CTLE step start pulse |
| txeq_start | output | LANES | Per-lane TX-equalization start pulse |
| train_done | output | LANES | Per-lane training-complete flag |
| partner_cmd_sw | output | 1 | Partner update commands come from software |
| local_coef_sw | output | 1 | Local TX coefficients come from software |

## Verification
Every lane output is registered, so each result is due one clock after the edge that caused it. A restart clears `train_done` on the write edge itself. A start pulse follows on the next edge. A done input sampled at an edge produces the next start pulse or the completion flag after that same edge. The bench keeps a behavioural model per lane that it advances on every rising edge from the same inputs the design sees, and it compares all lane outputs and the selects at every falling edge, so each result is checked in the cycle it is due. Separate read-back checks run half a cycle after each write, because the read port is combinational.

// File: rtl/eq_step_seq.sv
module eq_step_seq #(
  parameter int LANES = 4,
  parameter int AW    = 2,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [LANES-1:0] ctle_done,
  input  logic [LANES-1:0] txeq_done,
  output logic [LANES-1:0] ctle_start,
  output logic [LANES-1:0] txeq_start,
  output logic [LANES-1:0] train_done,
  output logic             partner_cmd_sw,
  output logic             local_coef_sw
);
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_RST = AW'(1);
  localparam int CFG_W = 4;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TXEQ, S_POST, S_DONE} st_t;

  logic [1:0] mode_q;
  logic       lp_ov_q, loc_ov_q;
  logic [LANES-1:0] restart;

  assign restart = (wr_en && wr_addr == A_RST) ? wr_data[LANES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'b11;
      lp_ov_q  <= 1'b0;
      loc_ov_q <= 1'b0;
    end else if (wr_en && wr_addr == A_CFG) begin
      lp_ov_q  <= wr_data[0];
      loc_ov_q <= wr_data[1];
      mode_q   <= wr_data[3:2];
    end
  end

  assign rd_data = (rd_addr == A_CFG) ?
                   {{(DW-CFG_W){1'b0}}, mode_q, loc_ov_q, lp_ov_q} : '0;
  assign partner_cmd_sw = lp_ov_q;
  assign local_coef_sw  = loc_ov_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    st_t        st;
    logic [1:0] run_mode;
    logic       cs_q, ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st       <= S_IDLE;
        run_mode <= 2'b11;
        cs_q     <= 1'b0;
        ts_q     <= 1'b0;
      end else begin
        cs_q <= 1'b0;
        ts_q <= 1'b0;
        if (restart[g]) begin
          st <= S_IDLE;
        end else begin
          case (st)
            S_IDLE: begin
              run_mode <= mode_q;
              if (mode_q[0]) begin
                st   <= S_PRE;
                cs_q <= 1'b1;
              end else begin
                st   <= S_TXEQ;
                ts_q <= 1'b1;
              end
            end
            S_PRE: if (ctle_done[g]) begin
              st   <= S_TXEQ;
              ts_q <= 1'b1;
            end
            S_TXEQ: if (txeq_done[g]) begin
              if (run_mode[1]) begin
                st   <= S_POST;
                cs_q <= 1'b1;
              end else begin
                st <= S_DONE;
              end
            end
            S_POST: if (ctle_done[g]) st <= S_DONE;
            default: st <= S_DONE;
          endcase
        end
      end
    end

    assign ctle_start[g] = cs_q;
    assign txeq_start[g] = ts_q;
    assign train_done[g] = (st == S_DONE);
  end
endmodule

module eq_step_seq_chk #(
  parameter int LANES = 4,
  parameter int AW    = 2,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    rd_data,
  input logic [LANES-1:0] ctle_start,
  input logic [LANES-1:0] txeq_start,
  input logic [LANES-1:0] train_done,
  input logic             partner_cmd_sw,
  input logic             local_coef_sw
);
  AST_CTLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ctle_start & $past(ctle_start)) == '0)); // R6
  AST_TXEQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((txeq_start & $past(txeq_start)) == '0)); // R6
  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctle_start & txeq_start) == '0)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(1)) |=> ((train_done & $past(wr_data[LANES-1:0])) == '0)); // R7
  AST_PARTNER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0)) |=> (partner_cmd_sw == $past(wr_data[0]))); // R10
  AST_LOCAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0)) |=> (local_coef_sw == $past(wr_data[1]))); // R11
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DW-1:4] == '0)); // R12
endmodule

bind eq_step_seq eq_step_seq_chk #(.LANES(LANES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_data(rd_data), .ctle_start(ctle_start), .txeq_start(txeq_start),
  .train_done(train_done), .partner_cmd_sw(partner_cmd_sw),
  .local_coef_sw(local_coef_sw)
);

// File: tb/sim_eq_step_seq.sv
`timescale 1ns/1ps
module sim_eq_step_seq;
  localparam int L = 4;
  localparam int AW = 2;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [L-1:0] ctle_done = '0, txeq_done = '0;
  logic [L-1:0] ctle_start, txeq_start, train_done;
  logic partner_cmd_sw, local_coef_sw;

  always #5 clk = ~clk;

  eq_step_seq #(.LANES(L), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctle_done(ctle_done), .txeq_done(txeq_done),
    .ctle_start(ctle_start), .txeq_start(txeq_start), .train_done(train_done),
    .partner_cmd_sw(partner_cmd_sw), .local_coef_sw(local_coef_sw));

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model: 0 idle,1 pre,2 txeq,3 post,4 done
  int m_st[L];
  int m_rm[L];
  bit m_cs[L], m_ts[L];
  int m_mode = 3;
  bit m_lp = 0, m_loc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) begin m_st[i] = 0; m_cs[i] = 0; m_ts[i] = 0; m_rm[i] = 3; end
      m_mode = 3; m_lp = 0; m_loc = 0;
    end else begin
      for (int i = 0; i < L; i++) begin
        m_cs[i] = 0; m_ts[i] = 0;
        if (wr_en && wr_addr == 1 && wr_data[i]) m_st[i] = 0;
        else if (m_st[i] == 0) begin
          m_rm[i] = m_mode;
          if (m_mode % 2 == 1) begin m_st[i] = 1; m_cs[i] = 1; end
          else begin m_st[i] = 2; m_ts[i] = 1; end
        end else if (m_st[i] == 1) begin
          if (ctle_done[i]) begin m_st[i] = 2; m_ts[i] = 1; end
        end else if (m_st[i] == 2) begin
          if (txeq_done[i]) begin
            if (m_rm[i] >= 2) begin m_st[i] = 3; m_cs[i] = 1; end
            else m_st[i] = 4;
          end
        end else if (m_st[i] == 3) begin
          if (ctle_done[i]) m_st[i] = 4;
        end
      end
      if (wr_en && wr_addr == 0) begin
        m_lp = wr_data[0]; m_loc = wr_data[1]; m_mode = int'(wr_data[3:2]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against model
  always @(negedge clk) if (rst_n && !finished) begin
    for (int i = 0; i < L; i++) begin
      chk("R2 R3 R4 R5 R6 R9 ctle_start", {31'b0, ctle_start[i]}, {31'b0, m_cs[i]});
      chk("R2 R3 R4 R5 R6 R9 txeq_start", {31'b0, txeq_start[i]}, {31'b0, m_ts[i]});
      chk("R2 R3 R4 R5 R6 R7 R8 train_done", {31'b0, train_done[i]}, {31'b0, m_st[i] == 4});
    end
    chk("R10 partner_cmd_sw", {31'b0, partner_cmd_sw}, {31'b0, m_lp});
    chk("R11 local_coef_sw", {31'b0, local_coef_sw}, {31'b0, m_loc});
  end

  // engine responders
  int c_cnt[L], t_cnt[L];
  int dly[L] = '{1, 2, 3, 5};
  bit hold_tx[L];
  int cs_count3 = 0;
  always @(negedge clk) begin
    for (int i = 0; i < L; i++) begin
      ctle_done[i] <= 1'b0;
      txeq_done[i] <= 1'b0;
      if (c_cnt[i] > 0) begin
        c_cnt[i]--;
        if (c_cnt[i] == 0) ctle_done[i] <= 1'b1;
      end
      if (t_cnt[i] > 0 && !hold_tx[i]) begin
        t_cnt[i]--;
        if (t_cnt[i] == 0) txeq_done[i] <= 1'b1;
      end
      if (ctle_start[i]) c_cnt[i] = dly[i];
      if (txeq_start[i]) t_cnt[i] = dly[i] + 1;
    end
    if (ctle_start[3]) cs_count3++;
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic restart_lanes(input logic [L-1:0] m);
    for (int i = 0; i < L; i++) if (m[i]) begin c_cnt[i] = 0; t_cnt[i] = 0; end
    wr(1, {28'b0, m});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < L; i++) begin c_cnt[i] = 0; t_cnt[i] = 0; hold_tx[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_addr = 0;
    #1 chk("R1 reset config", rd_data, 32'h0000_000C);
    chk("R1 reset lane starts pending", {28'b0, train_done}, 32'h0);
    @(negedge clk);
    chk("R1 run began after reset", {28'b0, ctle_start}, 32'hF);
    repeat (40) @(negedge clk);
    chk("R5 all lanes done mode 11", {28'b0, train_done}, 32'hF);
    chk("R5 two ctle pulses lane 3", cs_count3, 2);

    // R8: restart write of zero
    wr(1, 32'h0);
    chk("R8 zero restart no effect", {28'b0, train_done}, 32'hF);
    repeat (3) @(negedge clk);
    chk("R8 still done", {28'b0, train_done}, 32'hF);

    // R2 mode 00 on lane 0
    wr(0, 32'h0);
    restart_lanes(4'b0001);
    chk("R7 lane0 cleared", {28'b0, train_done}, 32'hE);
    rd_addr = 1;
    #1 chk("R7 restart reads 0", rd_data, 32'h0);
    repeat (20) @(negedge clk);
    chk("R2 lane0 done", {31'b0, train_done[0]}, 32'h1);

    // R3 mode 01 lane 1
    wr(0, 32'h4);
    restart_lanes(4'b0010);
    repeat (25) @(negedge clk);
    chk("R3 lane1 done", {31'b0, train_done[1]}, 32'h1);

    // R4 mode 10 lane 2
    wr(0, 32'h8);
    restart_lanes(4'b0100);
    repeat (30) @(negedge clk);
    chk("R4 lane2 done", {31'b0, train_done[2]}, 32'h1);

    // R9 mode 11 run on lane 3, mode changed mid-run
    wr(0, 32'hC);
    cs_count3 = 0;
    restart_lanes(4'b1000);
    repeat (2) @(negedge clk);
    wr(0, 32'h0);
    repeat (40) @(negedge clk);
    chk("R9 lane3 kept captured mode", cs_count3, 2);
    chk("R9 lane3 done", {31'b0, train_done[3]}, 32'h1);

    // R6 waiting without done
    hold_tx[0] = 1;
    restart_lanes(4'b0001);
    repeat (30) @(negedge clk);
    chk("R6 lane0 waits for txeq_done", {31'b0, train_done[0]}, 32'h0);
    hold_tx[0] = 0;
    repeat (10) @(negedge clk);
    chk("R6 lane0 finishes after done", {31'b0, train_done[0]}, 32'h1);

    // R10 R11 R12 overrides and reserved bits
    wr(0, 32'hFFFF_FFF3);
    rd_addr = 0;
    #1 chk("R12 reserved ignored", rd_data, 32'h0000_0003);
    chk("R10 partner select", {31'b0, partner_cmd_sw}, 32'h1);
    chk("R11 local select", {31'b0, local_coef_sw}, 32'h1);
    wr(2, 32'hFFFF_FFFF);
    rd_addr = 2;
    #1 chk("R12 unmapped reads 0", rd_data, 32'h0);
    rd_addr = 0;
    #1 chk("R12 unmapped write ignored", rd_data, 32'h0000_0003);
    wr(0, 32'h2);
    chk("R10 partner back to training", {31'b0, partner_cmd_sw}, 32'h0);
    chk("R11 local stays software", {31'b0, local_coef_sw}, 32'h1);

    // restart all lanes at once with mode 00
    restart_lanes(4'b1111);
    chk("R7 all cleared", {28'b0, train_done}, 32'h0);
    @(negedge clk);
    chk("R7 R2 new run txeq first", {28'b0, txeq_start}, 32'hF);
    repeat (20) @(negedge clk);
    chk("R2 all done", {28'b0, train_done}, 32'hF);

    finished = 1;
    finish_run();
  end
endmodule